// File: doc/BRIEF.md
# Vertical-Blanking Pseudo-Sync Pulse Detector

This block watches a standard-definition or progressive-scan video timing stream, clocked at the pixel rate, for the extra narrow sync pulses that copy-protection schemes insert into vertical-blanking lines. It counts lines from the start of each field. Inside a programmable line window it measures every low-going pulse of the composite sync level and counts the pulses whose width falls in a programmable range.

Once per field, on the line after the window closes, it updates a single detected flag and strobes an update-valid output for one cycle. The flag is set only when at least one qualifying pulse was seen. In standard-definition mode the last three lines of the window must also carry enough qualifying pulses. Line window and width limits come either from programmed inputs or from built-in presets chosen by a 525/625-line standard select. A double-rate sampling option doubles both width limits.

Top module: `vbi_pulse_det`

## Requirements
- R1: While reset is asserted and after its release, `det_o` and `det_vld_o` are 0 until the first update.
- R2: A rising edge of `vsync_i` sets the line number to 0. Every other rising edge of `hsync_i` adds one. When both rise in the same cycle, the line number becomes 0.
- R3: A pulse's width is the number of consecutive clock cycles in which `csync_i` is sampled low; the count saturates at 31. A pulse qualifies only if min <= width <= max.
- R4: A pulse counts only if the line number when it ends lies in [start, end], both inclusive.
- R5: `det_vld_o` is high for exactly one cycle, the cycle after the `hsync_i` rising edge that moves the line number from end to end+1. `det_o` takes its new value in that cycle and holds it until the next update.
- R6: At an update, `det_o` is 1 only if at least one qualifying pulse was counted since the last `vsync_i` rising edge, and the tail check of R8 passes.
- R7: `cfg_lim_i` encodes the required tail pulse count: 00 -> 2, 01 -> 4, 10 -> 6, 11 -> 8.
- R8: In standard-definition mode (`cfg_prog_i`=0), the tail check passes only if the number of qualifying pulses on lines end-2 through end is at least the count from R7. When the check fails, the field reports 0.
- R9: With `cfg_ovr_i`=0 the limits are presets: widths 6..9, with lines 13..21 when `cfg_pal_i`=0 and lines 8..16 when `cfg_pal_i`=1. With `cfg_ovr_i`=1 the four programmed inputs are used.
- R10: With `cfg_ovs_i`=1, both width limits are compared at twice their value.
- R11: In progressive mode (`cfg_prog_i`=1), the tail check is skipped. One qualifying pulse is then enough.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csync_i | input | 1 | Composite sync level, low during a pulse |
| vsync_i | input | 1 | Vertical sync, rising edge starts a field |
| hsync_i | input | 1 | Horizontal sync, rising edge starts a line |
| cfg_wmin_i | input | 4 | Programmed minimum pulse width |
| cfg_wmax_i | input | 4 | Programmed maximum pulse width |
| cfg_lstart_i | input | 6 | Programmed first window line |
| cfg_lend_i | input | 6 | Programmed last window line |
| cfg_pal_i | input | 1 | 0: 525-line presets, 1: 625-line presets |
| cfg_prog_i | input | 1 | 0: standard definition, 1: progressive scan |
| cfg_ovs_i | input | 1 | Double-rate sampling, doubles the width limits |
| cfg_ovr_i | input | 1 | 0: presets, 1: programmed limits |
| cfg_lim_i | input | 2 | Tail pulse count select |
| det_o | output | 1 | Per-field detected flag |
| det_vld_o | output | 1 | One-cycle strobe when `det_o` is updated |

## Verification
The assertions assume that configuration inputs change only between fields. They also assume that `hsync_i` stays low for at least one cycle between rising edges, so two updates can never fall in adjacent cycles. The stimulus writes configuration only before each `vsync_i` pulse and holds every sync high for several cycles. Pulses end well away from the `hsync_i` edges, so no qualifying pulse lands in the cycle of an update, and the window end stays below the last generated line.

// File: rtl/vpd_pkg.sv
package vpd_pkg;
  localparam int VPD_TW     = 4;
  localparam int VPD_LW     = 6;
  localparam int VPD_CNT_W  = 8;
  localparam int VPD_TAIL_W = 4;

  // built-in limits used when the override select is clear
  localparam int PRE_WMIN    = 6;
  localparam int PRE_WMAX    = 9;
  localparam int PRE525_FIRST = 13;
  localparam int PRE525_LAST  = 21;
  localparam int PRE625_FIRST = 8;
  localparam int PRE625_LAST  = 16;
endpackage

// File: rtl/vpd_thresh.sv
module vpd_thresh
  import vpd_pkg::*;
#(
  parameter int TW = VPD_TW,
  parameter int LW = VPD_LW
) (
  input  logic [TW-1:0] cfg_wmin_i,
  input  logic [TW-1:0] cfg_wmax_i,
  input  logic [LW-1:0] cfg_lstart_i,
  input  logic [LW-1:0] cfg_lend_i,
  input  logic          cfg_pal_i,
  input  logic          cfg_ovs_i,
  input  logic          cfg_ovr_i,
  output logic [TW:0]   wmin_o,
  output logic [TW:0]   wmax_o,
  output logic [LW-1:0] lstart_o,
  output logic [LW-1:0] lend_o
);
  logic [TW-1:0] src_min, src_max;

  always_comb begin
    if (cfg_ovr_i) begin
      src_min  = cfg_wmin_i;
      src_max  = cfg_wmax_i;
      lstart_o = cfg_lstart_i;
      lend_o   = cfg_lend_i;
    end else begin
      src_min  = TW'(PRE_WMIN);
      src_max  = TW'(PRE_WMAX);
      lstart_o = cfg_pal_i ? LW'(PRE625_FIRST) : LW'(PRE525_FIRST);
      lend_o   = cfg_pal_i ? LW'(PRE625_LAST)  : LW'(PRE525_LAST);
    end
  end

  // double-rate sampling: compare against twice the nominal limits
  always_comb begin
    if (cfg_ovs_i) begin
      wmin_o = {src_min, 1'b0};
      wmax_o = {src_max, 1'b0};
    end else begin
      wmin_o = {1'b0, src_min};
      wmax_o = {1'b0, src_max};
    end
  end
endmodule

// File: rtl/vpd_sync_track.sv
module vpd_sync_track
  import vpd_pkg::*;
#(
  parameter int LW = VPD_LW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vsync_i,
  input  logic          hsync_i,
  output logic          vs_rise_o,
  output logic          hs_rise_o,
  output logic [LW-1:0] line_o
);
  logic          vs_q, hs_q;
  logic [LW-1:0] line_q, line_d;

  assign vs_rise_o = vsync_i & ~vs_q;
  assign hs_rise_o = hsync_i & ~hs_q;
  assign line_o    = line_q;

  always_comb begin
    line_d = line_q;
    if (vs_rise_o)
      line_d = '0;
    else if (hs_rise_o && (line_q != '1))
      line_d = line_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vs_q   <= 1'b0;
      hs_q   <= 1'b0;
      line_q <= '0;
    end else begin
      vs_q   <= vsync_i;
      hs_q   <= hsync_i;
      line_q <= line_d;
    end
  end
endmodule

// File: rtl/vpd_width_meas.sv
module vpd_width_meas
  import vpd_pkg::*;
#(
  parameter int CW = VPD_TW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          csync_i,
  output logic          pend_o,
  output logic [CW-1:0] width_o
);
  logic          cs_q;
  logic [CW-1:0] cnt_q, cnt_d;

  // pulse ends when the level is first sampled high again
  assign pend_o  = csync_i & ~cs_q;
  assign width_o = cnt_q;

  always_comb begin
    if (csync_i)
      cnt_d = '0;
    else if (cnt_q == '1)
      cnt_d = cnt_q;
    else
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q  <= 1'b1;
      cnt_q <= '0;
    end else begin
      cs_q  <= csync_i;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/vbi_pulse_det.sv
module vbi_pulse_det
  import vpd_pkg::*;
#(
  parameter int TW     = VPD_TW,
  parameter int LW     = VPD_LW,
  parameter int CNT_W  = VPD_CNT_W,
  parameter int TAIL_W = VPD_TAIL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          csync_i,
  input  logic          vsync_i,
  input  logic          hsync_i,
  input  logic [TW-1:0] cfg_wmin_i,
  input  logic [TW-1:0] cfg_wmax_i,
  input  logic [LW-1:0] cfg_lstart_i,
  input  logic [LW-1:0] cfg_lend_i,
  input  logic          cfg_pal_i,
  input  logic          cfg_prog_i,
  input  logic          cfg_ovs_i,
  input  logic          cfg_ovr_i,
  input  logic [1:0]    cfg_lim_i,
  output logic          det_o,
  output logic          det_vld_o
);
  localparam int CW = TW + 1;

  logic              vs_rise, hs_rise, pend;
  logic [LW-1:0]     line_q, lstart, lend;
  logic [CW-1:0]     width, wmin, wmax;
  logic              in_win, in_tail, hit, upd, pass;
  logic [TAIL_W-1:0] need;
  logic [CNT_W-1:0]  tot_q, tot_d;
  logic [TAIL_W-1:0] tail_q, tail_d;
  logic              det_q, det_d, vld_q, vld_d;

  vpd_thresh #(.TW(TW), .LW(LW)) u_thresh (
    .cfg_wmin_i(cfg_wmin_i), .cfg_wmax_i(cfg_wmax_i),
    .cfg_lstart_i(cfg_lstart_i), .cfg_lend_i(cfg_lend_i),
    .cfg_pal_i(cfg_pal_i), .cfg_ovs_i(cfg_ovs_i), .cfg_ovr_i(cfg_ovr_i),
    .wmin_o(wmin), .wmax_o(wmax), .lstart_o(lstart), .lend_o(lend)
  );

  vpd_sync_track #(.LW(LW)) u_sync (
    .clk(clk), .rst_n(rst_n), .vsync_i(vsync_i), .hsync_i(hsync_i),
    .vs_rise_o(vs_rise), .hs_rise_o(hs_rise), .line_o(line_q)
  );

  vpd_width_meas #(.CW(CW)) u_meas (
    .clk(clk), .rst_n(rst_n), .csync_i(csync_i),
    .pend_o(pend), .width_o(width)
  );

  // window, tail region and qualifying pulse
  assign in_win  = (line_q >= lstart) && (line_q <= lend);
  assign in_tail = in_win && (({1'b0, line_q} + (LW+1)'(2)) >= {1'b0, lend});
  assign hit     = pend && in_win && (width >= wmin) && (width <= wmax);

  // required tail count: 2 * (select + 1)
  assign need = TAIL_W'({cfg_lim_i, 1'b1}) + TAIL_W'(1);
  assign pass = (tot_q != '0) && (cfg_prog_i || (tail_q >= need));
  assign upd  = hs_rise && !vs_rise && (line_q == lend) && (lend != '1);

  always_comb begin
    tot_d  = tot_q;
    tail_d = tail_q;
    if (vs_rise) begin
      tot_d  = '0;
      tail_d = '0;
    end else if (hit) begin
      if (tot_q != '1)
        tot_d = tot_q + 1'b1;
      if (in_tail && (tail_q != '1))
        tail_d = tail_q + 1'b1;
    end
  end

  always_comb begin
    det_d = det_q;
    vld_d = 1'b0;
    if (upd) begin
      det_d = pass;
      vld_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tot_q  <= '0;
      tail_q <= '0;
      det_q  <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      tot_q  <= tot_d;
      tail_q <= tail_d;
      det_q  <= det_d;
      vld_q  <= vld_d;
    end
  end

  assign det_o     = det_q;
  assign det_vld_o = vld_q;
endmodule

// File: rtl/vpd_checker.sv
module vpd_checker #(
  parameter int LW     = 6,
  parameter int CNT_W  = 8,
  parameter int TAIL_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              vs_rise,
  input logic              hs_rise,
  input logic [LW-1:0]     line_q,
  input logic [CNT_W-1:0]  tot_q,
  input logic [TAIL_W-1:0] tail_q,
  input logic              det_o,
  input logic              det_vld_o
);
  p_line_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    vs_rise |=> (line_q == '0));

  p_line_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_rise && !vs_rise && (line_q != '1)) |=> (line_q == $past(line_q) + 1'b1));

  p_vld_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    det_vld_o |=> !det_vld_o);

  p_det_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !det_vld_o |-> $stable(det_o));

  p_det_needs_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (det_vld_o && det_o) |-> ($past(tot_q) != '0));

  p_cnt_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vs_rise |=> ((tot_q == '0) && (tail_q == '0)));

  p_tail_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ({{(CNT_W-TAIL_W){1'b0}}, tail_q} <= tot_q));
endmodule

bind vbi_pulse_det vpd_checker #(.LW(LW), .CNT_W(CNT_W), .TAIL_W(TAIL_W)) u_vpd_checker (
  .clk(clk), .rst_n(rst_n), .vs_rise(vs_rise), .hs_rise(hs_rise),
  .line_q(line_q), .tot_q(tot_q), .tail_q(tail_q),
  .det_o(det_o), .det_vld_o(det_vld_o)
);

// File: tb/test_vbi_pulse_det.sv
module test_vbi_pulse_det;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csync = 1'b1, vsync = 1'b0, hsync = 1'b0;
  logic [3:0] c_min = 4'd6, c_max = 4'd9;
  logic [5:0] c_start = 6'd13, c_end = 6'd21;
  logic c_pal = 1'b0, c_prog = 1'b0, c_ovs = 1'b0, c_ovr = 1'b0;
  logic [1:0] c_lim = 2'b00;
  logic det, vld;

  int n_chk = 0, n_err = 0;
  int pc = 0;
  int upd_pc = -1;
  bit last_det = 1'b0;
  bit exp_q[$];
  bit done = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) pc <= pc + 1;

  vbi_pulse_det i_vbi_pulse_det (
    .clk(clk), .rst_n(rst_n), .csync_i(csync), .vsync_i(vsync), .hsync_i(hsync),
    .cfg_wmin_i(c_min), .cfg_wmax_i(c_max), .cfg_lstart_i(c_start), .cfg_lend_i(c_end),
    .cfg_pal_i(c_pal), .cfg_prog_i(c_prog), .cfg_ovs_i(c_ovs), .cfg_ovr_i(c_ovr),
    .cfg_lim_i(c_lim), .det_o(det), .det_vld_o(vld)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      #2;
    end
  endtask

  function automatic int eff_start();
    if (c_ovr) return int'(c_start);
    return c_pal ? 8 : 13;
  endfunction

  function automatic int eff_end();
    if (c_ovr) return int'(c_end);
    return c_pal ? 16 : 21;
  endfunction

  // model of one field: pulses of widths w1 (and w2 if nonzero) on lines first..last
  function automatic bit model(input int first, input int last, input int w1, input int w2);
    int lo, hi, s, e, tot, tail, need;
    lo = c_ovr ? int'(c_min) : 6;
    hi = c_ovr ? int'(c_max) : 9;
    if (c_ovs) begin
      lo = lo * 2;
      hi = hi * 2;
    end
    s = eff_start();
    e = eff_end();
    tot = 0;
    tail = 0;
    for (int ln = first; ln <= last; ln++) begin
      if (ln >= s && ln <= e) begin
        for (int k = 0; k < 2; k++) begin
          int w;
          w = (k == 0) ? w1 : w2;
          if (w > 31) w = 31;
          if (w > 0 && w >= lo && w <= hi) begin
            tot++;
            if (ln >= e - 2) tail++;
          end
        end
      end
    end
    need = 2 * (int'(c_lim) + 1);
    return (tot > 0) && (c_prog || tail >= need);
  endfunction

  task automatic field(input int first, input int last, input int w1, input int w2,
                       input bit coinc, input string req);
    int e;
    // R5: flag holds its previous value between updates
    chk(det == last_det, "R5 hold", det, last_det);
    exp_q.push_back(model(first, last, w1, w2));
    e = eff_end();
    vsync = 1'b1;
    if (coinc) hsync = 1'b1;
    step(3);
    vsync = 1'b0;
    hsync = 1'b0;
    step(20);
    for (int ln = 1; ln <= 30; ln++) begin
      hsync = 1'b1;
      if (ln == e + 1) upd_pc = pc + 1;
      step(4);
      hsync = 1'b0;
      step(6);
      if (ln >= first && ln <= last) begin
        csync = 1'b0;
        step(w1);
        csync = 1'b1;
        step(50 - w1);
        if (w2 > 0) begin
          csync = 1'b0;
          step(w2);
          csync = 1'b1;
          step(40 - w2);
        end else begin
          step(40);
        end
      end else begin
        step(90);
      end
    end
    if (req.len() == 0) n_chk = n_chk;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && vld && !done) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5 unexpected update", 1, 0);
      end else begin
        bit e;
        e = exp_q.pop_front();
        chk(det == e, "R6 detected flag", det, e);
        chk(pc == upd_pc, "R5 update cycle", pc, upd_pc);
        last_det = e;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    step(3);
    chk(det == 1'b0, "R1 det in reset", det, 0);
    chk(vld == 1'b0, "R1 vld in reset", vld, 0);
    rst_n = 1'b1;
    step(5);
    chk(det == 1'b0, "R1 det after reset", det, 0);
    chk(vld == 1'b0, "R1 vld after reset", vld, 0);

    // R9 525-line presets, R6 basic detection
    field(13, 21, 7, 7, 1'b0, "R9");
    // R8 no pulses in the tail lines
    field(13, 18, 7, 7, 1'b0, "R8");
    // R7 select 01 needs 4, only 3 tail pulses
    c_lim = 2'b01;
    field(19, 21, 6, 0, 1'b0, "R7");
    c_lim = 2'b00;
    field(19, 21, 6, 0, 1'b0, "R7");
    // R7 select 11 needs 8, 10 needs 6
    c_lim = 2'b11;
    field(19, 21, 8, 9, 1'b0, "R7");
    c_lim = 2'b10;
    field(19, 21, 8, 9, 1'b0, "R7");
    // R11 progressive skips the tail check
    c_lim = 2'b11;
    c_prog = 1'b1;
    field(13, 14, 7, 0, 1'b0, "R11");
    // R3 width limits
    field(13, 21, 5, 10, 1'b0, "R3");
    field(13, 13, 9, 0, 1'b0, "R3");
    field(21, 21, 6, 0, 1'b0, "R3");
    // R4 window edges
    field(12, 12, 7, 0, 1'b0, "R4");
    field(22, 22, 7, 0, 1'b0, "R4");
    // R2 vsync wins over coincident hsync
    field(21, 21, 7, 0, 1'b1, "R2");
    // R9 625-line presets
    c_pal = 1'b1;
    field(17, 20, 7, 0, 1'b0, "R9");
    c_prog = 1'b0;
    c_lim = 2'b00;
    field(8, 16, 7, 7, 1'b0, "R9");
    // R9 programmed limits
    c_pal = 1'b0;
    c_ovr = 1'b1;
    c_min = 4'd3;
    c_max = 4'd4;
    c_start = 6'd5;
    c_end = 6'd7;
    field(5, 7, 4, 4, 1'b0, "R9");
    field(5, 7, 6, 6, 1'b0, "R9");
    // R10 double-rate thresholds 30..30 and saturation
    c_ovs = 1'b1;
    c_prog = 1'b1;
    c_min = 4'd15;
    c_max = 4'd15;
    field(6, 6, 30, 0, 1'b0, "R10");
    field(6, 6, 40, 0, 1'b0, "R3");
    // R10 presets doubled to 12..18
    c_ovr = 1'b0;
    field(13, 13, 18, 11, 1'b0, "R10");
    field(13, 13, 11, 19, 1'b0, "R10");
    step(20);
    done = 1'b1;
    chk(exp_q.size() == 0, "R5 every field updated", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule